// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Controller

This block keeps the tag state of a small direct-mapped, write-through cache coherent on a shared atomic bus. Each line is either valid or invalid. A processor read that finds its line valid completes locally. A read that misses, and every write, is placed on the bus after the bus arbiter grants it. A read miss then marks the line valid. A write never allocates a line.

The controller watches the bus for writes issued by other caches. A snooped write whose address matches a line this cache holds clears that line, so later local reads fetch the new value again. Invalidations therefore take effect in bus order. The processor holds its request until the controller signals completion, and it issues one operation at a time. A snoop that arrives in the same cycle as a new processor request is handled first. The address splits into a low index field, which selects the line, and an upper tag field, which is compared with the stored tag.

Top module: `wti_snoop_ctl`

## Requirements
- R1: After reset every line is invalid, and bus_req and cpu_done are low.
- R2: A read whose line is valid with an equal tag raises cpu_done with cpu_hit=1 one cycle after acceptance, with no bus request.
- R3: A read miss raises bus_req. In the grant cycle bus_issue is high, with bus_op=0 (read) and bus_addr equal to the request address. cpu_done follows one cycle later with cpu_hit=0, and the line becomes valid with the new tag.
- R4: Every write, hit or miss, raises bus_req and is issued with bus_op=1 (write). cpu_done follows one cycle after the grant with cpu_hit=0. A write hit leaves the line valid.
- R5: A write miss does not allocate: the line keeps its previous valid state and tag.
- R6: A snooped write (snoop_valid=1, snoop_wr=1) whose index and tag match a valid line makes that line invalid.
- R7: A snooped read (snoop_wr=0), or a snooped write whose tag differs from the stored one, leaves the line unchanged.
- R8: bus_req stays high, and nothing is issued, until bus_gnt is seen. Any number of wait cycles is allowed.
- R9: A processor request is not accepted in a cycle with snoop_valid high. The lookup happens one cycle later and sees the state left by the snoop.
- R10: The line index is the low IDX_W address bits and the tag is the remaining upper bits. A read miss to an occupied index replaces the older tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | With cpu_done: completed without the bus |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_issue | output | 1 | Transaction placed on the bus this cycle |
| bus_op | output | 1 | 0 = bus read, 1 = bus write |
| bus_addr | output | ADDR_W | Address of the issued transaction |
| snoop_valid | input | 1 | A transaction from another cache is on the bus |
| snoop_wr | input | 1 | Snooped transaction type, 1 = write |
| snoop_addr | input | ADDR_W | Snooped address |

## Verification
The hardest case to reach is a snoop that lands in the same cycle a processor request would be looked up. Here the ordering decides whether the read hits stale data. The bench raises the request and a matching snooped write on the same clock edge. It then checks two things: no completion appears one cycle later, and the delayed lookup misses and goes to the bus. It repeats this with a snooped read, which must still let the read hit. Grant delays of several lengths are swept across all addresses of a 4-line configuration, so that bus_req is shown to hold steady while the bench stalls the grant.

// File: rtl/wtsi_pkg.sv
package wtsi_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUS  = 2'd1,
      ST_RESP = 2'd2
   } ctl_state_e;

   localparam logic OP_RD = 1'b0;
   localparam logic OP_WR = 1'b1;
endpackage

// File: rtl/wtsi_tag_store.sv
module wtsi_tag_store #(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              snp_valid,
   input  logic              snp_wr,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_kill
);
   localparam int LINES = 1 << IDX_W;
   localparam int TAG_W = ADDR_W - IDX_W;

   logic             valid_q [LINES];
   logic [TAG_W-1:0] tag_q   [LINES];
   logic [LINES-1:0] valid_vec;

   logic [IDX_W-1:0] lk_idx, fill_idx, snp_idx;
   logic [TAG_W-1:0] lk_tag, fill_tag, snp_tag;

   assign lk_idx   = lk_addr[IDX_W-1:0];
   assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
   assign fill_idx = fill_addr[IDX_W-1:0];
   assign fill_tag = fill_addr[ADDR_W-1:IDX_W];
   assign snp_idx  = snp_addr[IDX_W-1:0];
   assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];

   assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign snp_kill = snp_valid && snp_wr && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         logic kill_here, fill_here;
         assign kill_here = snp_kill && (snp_idx == IDX_W'(i));
         assign fill_here = fill_en && (fill_idx == IDX_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q[i] <= 1'b0;
               tag_q[i]   <= '0;
            end else if (kill_here) begin
               valid_q[i] <= 1'b0;
            end else if (fill_here) begin
               valid_q[i] <= 1'b1;
               tag_q[i]   <= fill_tag;
            end
         end
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < LINES; k++) valid_vec[k] = valid_q[k];
   end

   // R6: a matching snooped write leaves the line invalid
   a_r6_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      snp_kill |=> !valid_vec[$past(snp_idx)]);

   // R3: a read fill leaves its line valid
   a_r3_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !snp_kill) |=> valid_vec[$past(fill_idx)]);

   // R7: a snooped read never changes any valid bit
   a_r7_read_snoop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !snp_wr && !fill_en) |=> $stable(valid_vec));
endmodule

// File: rtl/wtsi_ctrl.sv
module wtsi_ctrl
   import wtsi_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   output logic              cpu_hit,
   input  logic              lk_hit,
   input  logic              snp_valid,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_issue,
   output logic              bus_op,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              fill_en,
   output logic [ADDR_W-1:0] fill_addr
);
   ctl_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic              hit_q;
   logic              accept;

   // snoop compare has priority over a new processor lookup
   assign accept    = (state_q == ST_IDLE) && cpu_req && !snp_valid;

   assign bus_req   = (state_q == ST_BUS);
   assign bus_issue = bus_req && bus_gnt;
   assign bus_op    = wr_q ? OP_WR : OP_RD;
   assign bus_addr  = addr_q;
   assign fill_en   = bus_issue && !wr_q;
   assign fill_addr = addr_q;
   assign cpu_done  = (state_q == ST_RESP);
   assign cpu_hit   = hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         hit_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               addr_q <= cpu_addr;
               wr_q   <= cpu_wr;
               if (!cpu_wr && lk_hit) begin
                  hit_q   <= 1'b1;
                  state_q <= ST_RESP;
               end else begin
                  hit_q   <= 1'b0;
                  state_q <= ST_BUS;
               end
            end
            ST_BUS:  if (bus_gnt) state_q <= ST_RESP;
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: the request is held until granted
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> bus_req);

   // R2: a local hit completes without having used the bus
   a_r2_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && cpu_hit) |-> !$past(bus_req));

   // R4: an accepted write always goes to the bus
   a_r4_write_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cpu_wr) |=> bus_req);

   // R9: no request is taken while a snoop is present
   a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && snp_valid) |=> (!cpu_done && !bus_req));
endmodule

// File: rtl/wti_snoop_ctl.sv
module wti_snoop_ctl #(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_issue,
   output logic              bus_op,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              snoop_valid,
   input  logic              snoop_wr,
   input  logic [ADDR_W-1:0] snoop_addr
);
   generate
      if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_index
         $error("wti_snoop_ctl: IDX_W must lie in 1..ADDR_W-1");
      end
      if (IDX_W > 10) begin : g_bad_depth
         $error("wti_snoop_ctl: tag array too deep");
      end
   endgenerate

   logic              lk_hit, snp_kill, fill_en;
   logic [ADDR_W-1:0] fill_addr;

   wtsi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_req  (cpu_req),
      .cpu_wr   (cpu_wr),
      .cpu_addr (cpu_addr),
      .cpu_done (cpu_done),
      .cpu_hit  (cpu_hit),
      .lk_hit   (lk_hit),
      .snp_valid(snoop_valid),
      .bus_req  (bus_req),
      .bus_gnt  (bus_gnt),
      .bus_issue(bus_issue),
      .bus_op   (bus_op),
      .bus_addr (bus_addr),
      .fill_en  (fill_en),
      .fill_addr(fill_addr)
   );

   wtsi_tag_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_addr  (cpu_addr),
      .lk_hit   (lk_hit),
      .fill_en  (fill_en),
      .fill_addr(fill_addr),
      .snp_valid(snoop_valid),
      .snp_wr   (snoop_wr),
      .snp_addr (snoop_addr),
      .snp_kill (snp_kill)
   );

   // R6: a killing snoop never coincides with an own issue on the atomic bus
   a_r6_bus_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      snp_kill |-> !bus_issue);
endmodule

// File: tb/wti_snoop_ctl_test.sv
module wti_snoop_ctl_test;
   localparam int AW = 5;
   localparam int IW = 2;
   localparam int NL = 1 << IW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 0, cpu_wr = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic cpu_done, cpu_hit, bus_req, bus_issue, bus_op;
   logic bus_gnt = 0;
   logic [AW-1:0] bus_addr;
   logic snoop_valid = 0, snoop_wr = 0;
   logic [AW-1:0] snoop_addr = '0;

   int tests = 0;
   int fails = 0;

   logic             m_valid [NL];
   logic [AW-IW-1:0] m_tag   [NL];

   always #10 clk = ~clk;

   wti_snoop_ctl #(.ADDR_W(AW), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_issue(bus_issue),
      .bus_op(bus_op), .bus_addr(bus_addr), .snoop_valid(snoop_valid),
      .snoop_wr(snoop_wr), .snoop_addr(snoop_addr)
   );

   task automatic check(input logic ok, input string rq, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic void model_snoop(input logic wr, input logic [AW-1:0] a);
      int ix = int'(a[IW-1:0]);
      if (wr && m_valid[ix] && m_tag[ix] == a[AW-1:IW]) m_valid[ix] = 1'b0;
   endfunction

   task automatic snoop(input logic wr, input logic [AW-1:0] a);
      @(negedge clk);
      snoop_valid = 1; snoop_wr = wr; snoop_addr = a;
      @(negedge clk);
      snoop_valid = 0; snoop_wr = 0;
      model_snoop(wr, a);
   endtask

   task automatic do_op(input logic wr, input logic [AW-1:0] a, input int gdly,
                        input logic snp, input logic swr, input logic [AW-1:0] sa,
                        input string rq);
      int  ix = int'(a[IW-1:0]);
      logic exp_hit;
      @(negedge clk);
      cpu_req = 1; cpu_wr = wr; cpu_addr = a;
      if (snp) begin
         snoop_valid = 1; snoop_wr = swr; snoop_addr = sa;
         model_snoop(swr, sa);
      end
      exp_hit = !wr && m_valid[ix] && (m_tag[ix] == a[AW-1:IW]);
      @(negedge clk);
      if (snp) begin
         snoop_valid = 0; snoop_wr = 0;
         check(!cpu_done && !bus_req, "R9", "request held back by snoop", int'(cpu_done), 0);
         @(negedge clk);
      end
      if (exp_hit) begin
         check(cpu_done == 1 && cpu_hit == 1, rq, "read hit done/hit", int'({cpu_done, cpu_hit}), 3);
         check(bus_req == 0, "R2", "hit uses no bus", int'(bus_req), 0);
      end else begin
         check(bus_req == 1 && cpu_done == 0, rq, "miss/write requests bus", int'(bus_req), 1);
         for (int w = 0; w < gdly; w++) begin
            @(negedge clk);
            check(bus_req == 1 && bus_issue == 0 && cpu_done == 0, "R8", "req held without grant",
                  int'(bus_req), 1);
         end
         bus_gnt = 1;
         #1;
         check(bus_issue == 1, rq, "issue in grant cycle", int'(bus_issue), 1);
         check(bus_op == wr, wr ? "R4" : "R3", "bus op", int'(bus_op), int'(wr));
         check(bus_addr == a, rq, "bus address", int'(bus_addr), int'(a));
         @(negedge clk);
         bus_gnt = 0;
         check(cpu_done == 1 && cpu_hit == 0, rq, "done after grant, no hit",
               int'({cpu_done, cpu_hit}), 2);
         if (!wr) begin
            m_valid[ix] = 1'b1;
            m_tag[ix]   = a[AW-IW-1+IW:IW];
         end
      end
      cpu_req = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(bus_req == 0 && cpu_done == 0, "R1", "idle after reset", int'({bus_req, cpu_done}), 0);

      // R1: first read of every line misses
      for (int i = 0; i < NL; i++) do_op(0, AW'(i), 0, 0, 0, '0, "R1");

      // R3, R10, R2: read sweep, then re-read hits; conflicting tags replace
      for (int a = 0; a < (1 << AW); a++) begin
         do_op(0, AW'(a), a % 3, 0, 0, '0, "R3");
         do_op(0, AW'(a), 0, 0, 0, '0, "R2");
      end
      for (int a = 0; a < NL; a++) do_op(0, AW'(a + NL), 1, 0, 0, '0, "R10");

      // R4 / R5: write sweep, each followed by a read probe
      for (int a = 0; a < (1 << AW); a++) begin
         do_op(1, AW'(a), a % 4, 0, 0, '0, "R4");
         do_op(0, AW'(a ^ (1 << IW)), 0, 0, 0, '0, "R5");
      end

      // R6 / R7: snoop behaviour per line
      for (int a = 0; a < NL; a++) begin
         do_op(0, AW'(a), 0, 0, 0, '0, "R3");
         snoop(0, AW'(a));
         do_op(0, AW'(a), 0, 0, 0, '0, "R7");
         snoop(1, AW'(a + 2 * NL));
         do_op(0, AW'(a), 0, 0, 0, '0, "R7");
         snoop(1, AW'(a));
         do_op(0, AW'(a), 2, 0, 0, '0, "R6");
      end

      // R9: snoop in the same cycle as a request
      for (int a = 0; a < NL; a++) begin
         do_op(0, AW'(a), 0, 1, 1, AW'(a), "R9");
         do_op(0, AW'(a), 0, 1, 0, AW'(a), "R9");
      end

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule